// File: doc/BRIEF.md
# ADC Sample Transport Packer

This block turns a stream of converter samples into octets for up to `NUM_LANES` serial lanes. The samples arrive one at a time on a valid/data pair and are right-justified in a 16-bit field. Three configuration inputs are treated as static register values: the resolution (12, 14 or 16 bits), the number of active lanes and the packing mode. In dense mode, consecutive samples are joined with no gaps into the shortest block that is a whole number of octets. In padded mode, each sample is stretched to a 16-bit word, so each frame holds exactly one sample.

Each finished block is cut into octets with the most significant bits first. The octets are handed out one per cycle, round-robin over the active lanes, and every block starts again at lane 0. A per-lane frame-start flag marks the first octet that each lane receives from a block. The configuration is sampled when the first sample of a block arrives, so a block already in progress always finishes under the settings it started with.

Top module: `adc_octet_packer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every lane valid bit, every frame-start bit and every octet output is 0.
- R2: With `cfg_padded`=0 (dense, the all-zero configuration), the resolution code `cfg_res` selects the block as follows. Code 0 means 12 bits, with 2 samples forming 3 octets. Code 1 means 14 bits, with 4 samples forming 7 octets. Codes 2 and 3 mean 16 bits, with 1 sample forming 2 octets. Within a block, the earliest sample takes the most significant position, and octets are sent from the most significant end.
- R3: With `cfg_padded`=1, every sample forms its own 2-octet block. The sample occupies the top bits of the 16-bit word and the filler bits below it are zero.
- R4: Bits of `smp_data` above the configured resolution have no effect on the octets sent.
- R5: Octet k of a block goes to lane k mod L, where L is the effective lane count. Lane l carries its octet on `lane_data[8l+7:8l]` and raises `lane_vld[l]`. At most one lane is valid in any cycle.
- R6: `lane_sof[l]` is 1 exactly when lane l carries an octet whose index within its block is below L. It is never 1 on a lane that is not valid.
- R7: Resolution, mode and lane count are captured with the first sample of a block. Changes made during a partly assembled block apply only from the next block.
- R8: A lane count of 0 acts as 1, and a count above `NUM_LANES` acts as `NUM_LANES`.
- R9: Octet k of a block is presented in the k-th cycle after the clock edge that accepts the block's last sample, one octet per cycle. All lane outputs are 0 whenever no octet is presented.
- R10: With samples accepted at most once every two cycles, consecutive blocks follow each other with no lost, repeated or merged octets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Sample, right-justified |
| cfg_res | input | 2 | Resolution code (0: 12, 1: 14, 2/3: 16 bits) |
| cfg_padded | input | 1 | 1: padded packing, 0: dense packing |
| cfg_lanes | input | $clog2(NUM_LANES+1) | Active lane count |
| lane_vld | output | NUM_LANES | Octet present on lane |
| lane_sof | output | NUM_LANES | First octet of a block on that lane |
| lane_data | output | 8*NUM_LANES | Octet per lane, lane 0 in the low byte |

## Verification
The bench targets the bit splicing in 14-bit dense blocks, where samples straddle octet edges. A wrong shift there would scramble the middle octets, such as the sixth octet that mixes two samples. It sets the unused high sample bits, so a missing mask would leak into the stream. It also changes the configuration halfway through a block: a design that re-reads settings on every sample would send a malformed block. Lane counts of 0 and 7, and blocks fed with no slack, catch lane indices that run past the end and blocks that overwrite one another.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int SMP_W     = 16;
    localparam int MAX_SPB   = 4;
    localparam int BLK_W     = SMP_W * MAX_SPB;
    localparam int BLKSH_W   = $clog2(BLK_W + 1);
    localparam int OCT_CNT_W = $clog2(BLK_W / 8 + 1);
    localparam int SPB_W     = $clog2(MAX_SPB + 1);

    typedef enum logic [1:0] {
        RES12  = 2'd0,
        RES14  = 2'd1,
        RES16  = 2'd2,
        RES16X = 2'd3
    } res_e;

    function automatic logic [BLKSH_W-1:0] res_width(res_e r);
        case (r)
            RES12:   return BLKSH_W'(12);
            RES14:   return BLKSH_W'(14);
            default: return BLKSH_W'(16);
        endcase
    endfunction

    function automatic logic [SPB_W-1:0] blk_smp(res_e r, logic pad);
        if (pad) return SPB_W'(1);
        case (r)
            RES12:   return SPB_W'(2);
            RES14:   return SPB_W'(4);
            default: return SPB_W'(1);
        endcase
    endfunction

    function automatic logic [OCT_CNT_W-1:0] blk_oct(res_e r, logic pad);
        if (pad) return OCT_CNT_W'(2);
        case (r)
            RES12:   return OCT_CNT_W'(3);
            RES14:   return OCT_CNT_W'(7);
            default: return OCT_CNT_W'(2);
        endcase
    endfunction
endpackage

// File: rtl/tp_assembler.sv
module tp_assembler
    import tp_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LCNT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     smp_data,
    input  logic [1:0]           cfg_res,
    input  logic                 cfg_padded,
    input  logic [LCNT_W-1:0]    cfg_lanes,
    output logic                 blk_load,
    output logic [BLK_W-1:0]     blk_bits,
    output logic [OCT_CNT_W-1:0] blk_octets,
    output logic [LCNT_W-1:0]    blk_lanes
);
    typedef struct packed {
        logic [BLK_W-1:0]  acc;
        logic [SPB_W-1:0]  cnt;
        res_e              res;
        logic              pad;
        logic [LCNT_W-1:0] lanes;
    } asm_t;

    asm_t s_d, s_q;

    logic [LCNT_W-1:0]  lanes_clamped;
    logic               first;
    res_e               c_res;
    logic               c_pad;
    logic [LCNT_W-1:0]  c_lanes;
    logic [BLKSH_W-1:0] w, ew, total;
    logic [SMP_W-1:0]   mask, word;
    logic [BLK_W-1:0]   wpos, base, nacc;
    logic [SPB_W-1:0]   spb;

    // Out-of-range lane counts fold into the legal range
    always_comb begin
        if (cfg_lanes == '0)
            lanes_clamped = LCNT_W'(1);
        else if (cfg_lanes > LCNT_W'(NUM_LANES))
            lanes_clamped = LCNT_W'(NUM_LANES);
        else
            lanes_clamped = cfg_lanes;
    end

    always_comb begin
        s_d     = s_q;
        first   = (s_q.cnt == '0);
        // Settings are taken only when a block begins
        c_res   = first ? res_e'(cfg_res) : s_q.res;
        c_pad   = first ? cfg_padded      : s_q.pad;
        c_lanes = first ? lanes_clamped   : s_q.lanes;

        w     = res_width(c_res);
        mask  = SMP_W'((BLK_W'(1) << w) - BLK_W'(1));
        word  = smp_data & mask;
        ew    = c_pad ? BLKSH_W'(SMP_W) : w;
        wpos  = c_pad ? (BLK_W'(word) << (BLKSH_W'(SMP_W) - w)) : BLK_W'(word);
        base  = first ? '0 : s_q.acc;
        nacc  = (base << ew) | wpos;
        spb   = blk_smp(c_res, c_pad);
        total = BLKSH_W'(spb) * ew;

        blk_load   = smp_valid && ((s_q.cnt + SPB_W'(1)) == spb);
        blk_bits   = nacc << (BLKSH_W'(BLK_W) - total);
        blk_octets = blk_oct(c_res, c_pad);
        blk_lanes  = c_lanes;

        if (smp_valid) begin
            s_d.acc   = nacc;
            s_d.cnt   = blk_load ? '0 : s_q.cnt + SPB_W'(1);
            s_d.res   = c_res;
            s_d.pad   = c_pad;
            s_d.lanes = c_lanes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.acc   <= '0;
            s_q.cnt   <= '0;
            s_q.res   <= RES12;
            s_q.pad   <= 1'b0;
            s_q.lanes <= LCNT_W'(1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tp_lane_emitter.sv
module tp_lane_emitter
    import tp_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LCNT_W    = 3,
    parameter int LIDX_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_load,
    input  logic [BLK_W-1:0]       blk_bits,
    input  logic [OCT_CNT_W-1:0]   blk_octets,
    input  logic [LCNT_W-1:0]      blk_lanes,
    output logic [NUM_LANES-1:0]   lane_vld,
    output logic [NUM_LANES-1:0]   lane_sof,
    output logic [8*NUM_LANES-1:0] lane_data
);
    typedef struct packed {
        logic [BLK_W-1:0]     sr;
        logic [OCT_CNT_W-1:0] left;
        logic [OCT_CNT_W-1:0] idx;
        logic [LIDX_W-1:0]    lane;
        logic [LCNT_W-1:0]    lanes;
    } em_t;

    em_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (blk_load) begin
            s_d.sr    = blk_bits;
            s_d.left  = blk_octets;
            s_d.idx   = '0;
            s_d.lane  = '0;
            s_d.lanes = blk_lanes;
        end else if (s_q.left != '0) begin
            s_d.sr   = s_q.sr << 8;
            s_d.left = s_q.left - OCT_CNT_W'(1);
            s_d.idx  = s_q.idx + OCT_CNT_W'(1);
            if ((LCNT_W'(s_q.lane) + LCNT_W'(1)) >= s_q.lanes)
                s_d.lane = '0;
            else
                s_d.lane = s_q.lane + LIDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sr    <= '0;
            s_q.left  <= '0;
            s_q.idx   <= '0;
            s_q.lane  <= '0;
            s_q.lanes <= LCNT_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    logic busy, head;
    assign busy = (s_q.left != '0);
    assign head = ({{LCNT_W{1'b0}}, s_q.idx} < {{OCT_CNT_W{1'b0}}, s_q.lanes});

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_vld[l]          = busy && (s_q.lane == LIDX_W'(l));
        assign lane_sof[l]          = lane_vld[l] && head;
        assign lane_data[8*l +: 8]  = lane_vld[l] ? s_q.sr[BLK_W-1 -: 8] : 8'h00;
    end
endmodule

// File: rtl/adc_octet_packer.sv
module adc_octet_packer
    import tp_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               smp_valid,
    input  logic [15:0]                        smp_data,
    input  logic [1:0]                         cfg_res,
    input  logic                               cfg_padded,
    input  logic [$clog2(NUM_LANES+1)-1:0]     cfg_lanes,
    output logic [NUM_LANES-1:0]               lane_vld,
    output logic [NUM_LANES-1:0]               lane_sof,
    output logic [8*NUM_LANES-1:0]             lane_data
);
    localparam int LCNT_W = $clog2(NUM_LANES + 1);
    localparam int LIDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic                 blk_load;
    logic [BLK_W-1:0]     blk_bits;
    logic [OCT_CNT_W-1:0] blk_octets;
    logic [LCNT_W-1:0]    blk_lanes;

    tp_assembler #(.NUM_LANES(NUM_LANES), .LCNT_W(LCNT_W)) i_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .cfg_res    (cfg_res),
        .cfg_padded (cfg_padded),
        .cfg_lanes  (cfg_lanes),
        .blk_load   (blk_load),
        .blk_bits   (blk_bits),
        .blk_octets (blk_octets),
        .blk_lanes  (blk_lanes)
    );

    tp_lane_emitter #(.NUM_LANES(NUM_LANES), .LCNT_W(LCNT_W), .LIDX_W(LIDX_W)) i_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_load   (blk_load),
        .blk_bits   (blk_bits),
        .blk_octets (blk_octets),
        .blk_lanes  (blk_lanes),
        .lane_vld   (lane_vld),
        .lane_sof   (lane_sof),
        .lane_data  (lane_data)
    );
endmodule

// File: rtl/adc_octet_packer_chk.sv
module adc_octet_packer_chk #(
    parameter int NUM_LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_LANES-1:0]   lane_vld,
    input logic [NUM_LANES-1:0]   lane_sof,
    input logic [8*NUM_LANES-1:0] lane_data
);
    logic [8*NUM_LANES-1:0] vld_mask;

    always_comb begin
        for (int l = 0; l < NUM_LANES; l++)
            vld_mask[8*l +: 8] = {8{lane_vld[l]}};
    end

    // R1: outputs quiet right after reset release
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lane_vld == '0 && lane_sof == '0));

    // R5: never two lanes at once
    p_single_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_vld));

    // R6: frame start only with a valid octet
    p_sof_with_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sof & ~lane_vld) == '0);

    // R6: first octet after an idle cycle opens a block on lane 0
    p_block_opens_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld != '0 && $past(lane_vld) == '0) |-> (lane_vld[0] && lane_sof[0]));

    // R9: idle lanes drive zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_data & ~vld_mask) == '0);
endmodule

bind adc_octet_packer adc_octet_packer_chk #(.NUM_LANES(NUM_LANES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_vld  (lane_vld),
    .lane_sof  (lane_sof),
    .lane_data (lane_data)
);

// File: tb/test_adc_octet_packer.sv
module test_adc_octet_packer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NL = 4;
    localparam int LW = $clog2(NL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [15:0]   smp_data = '0;
    logic [1:0]    cfg_res = '0;
    logic          cfg_padded = 1'b0;
    logic [LW-1:0] cfg_lanes = LW'(1);
    logic [NL-1:0]   lane_vld, lane_sof;
    logic [8*NL-1:0] lane_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_octet_packer #(.NUM_LANES(NL)) i_adc_octet_packer (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_res(cfg_res), .cfg_padded(cfg_padded), .cfg_lanes(cfg_lanes),
        .lane_vld(lane_vld), .lane_sof(lane_sof), .lane_data(lane_data)
    );

    typedef struct packed {
        logic [1:0]       res;
        logic             pad;
        logic [2:0]       lanes;
        logic [2:0]       elanes;
        logic [2:0]       nsmp;
        logic [0:3][15:0] smp;
        logic [3:0]       noct;
        logic [0:6][7:0]  oct;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R2 12-bit dense, one lane
        '{2'd0, 1'b0, 3'd1, 3'd1, 3'd2, {16'h0ABC, 16'h0123, 16'h0, 16'h0}, 4'd3,
          {8'hAB, 8'hC1, 8'h23, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R2 14-bit dense, octets straddle samples, two lanes
        '{2'd1, 1'b0, 3'd2, 3'd2, 3'd4, {16'h3FFF, 16'h0000, 16'h2AAA, 16'h1555}, 4'd7,
          {8'hFF, 8'hFC, 8'h00, 8'h0A, 8'hAA, 8'h95, 8'h55}},
        // R2 16-bit dense, four lanes
        '{2'd2, 1'b0, 3'd4, 3'd4, 3'd1, {16'hBEEF, 16'h0, 16'h0, 16'h0}, 4'd2,
          {8'hBE, 8'hEF, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R3 padded 12-bit
        '{2'd0, 1'b1, 3'd1, 3'd1, 3'd1, {16'h05A3, 16'h0, 16'h0, 16'h0}, 4'd2,
          {8'h5A, 8'h30, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R3 padded 14-bit, two lanes
        '{2'd1, 1'b1, 3'd2, 3'd2, 3'd1, {16'h1234, 16'h0, 16'h0, 16'h0}, 4'd2,
          {8'h48, 8'hD0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R4 high bits set above 12-bit resolution, three lanes
        '{2'd0, 1'b0, 3'd3, 3'd3, 3'd2, {16'hF123, 16'hE456, 16'h0, 16'h0}, 4'd3,
          {8'h12, 8'h34, 8'h56, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R5 14-bit on four lanes, wraps back to lane 0
        '{2'd1, 1'b0, 3'd4, 3'd4, 3'd4, {16'h0001, 16'h0002, 16'h0003, 16'h0004}, 4'd7,
          {8'h00, 8'h04, 8'h00, 8'h20, 8'h00, 8'hC0, 8'h04}},
        // R8 lane count 7 clamps to 4
        '{2'd1, 1'b0, 3'd7, 3'd4, 3'd4, {16'h0001, 16'h0002, 16'h0003, 16'h0004}, 4'd7,
          {8'h00, 8'h04, 8'h00, 8'h20, 8'h00, 8'hC0, 8'h04}},
        // R8 lane count 0 acts as 1
        '{2'd2, 1'b0, 3'd0, 3'd1, 3'd1, {16'hCAFE, 16'h0, 16'h0, 16'h0}, 4'd2,
          {8'hCA, 8'hFE, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R2 code 3 behaves as 16-bit
        '{2'd3, 1'b0, 3'd2, 3'd2, 3'd1, {16'h8001, 16'h0, 16'h0, 16'h0}, 4'd2,
          {8'h80, 8'h01, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}},
        // R3 padded 16-bit has no filler
        '{2'd2, 1'b1, 3'd1, 3'd1, 3'd1, {16'h7E5A, 16'h0, 16'h0, 16'h0}, 4'd2,
          {8'h7E, 8'h5A, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}}
    };

    task automatic chk_idle(string tag);
        checks++;
        if (lane_vld !== '0 || lane_sof !== '0 || lane_data !== '0) begin
            errors++;
            $display("FAIL %s idle: vld %b sof %b data %h expected all zero",
                     tag, lane_vld, lane_sof, lane_data);
        end
    endtask

    task automatic chk_oct(string tag, int k, logic [7:0] exp_d, int el);
        int               ln;
        logic [NL-1:0]    ev, es;
        logic [7:0]       ad;
        ln = k % el;
        ev = NL'(1) << ln;
        es = (k < el) ? ev : '0;
        ad = lane_data[ln*8 +: 8];
        checks++;
        if (lane_vld !== ev || lane_sof !== es || ad !== exp_d) begin
            errors++;
            $display("FAIL %s octet %0d: vld %b sof %b data %h expected vld %b sof %b data %h",
                     tag, k, lane_vld, lane_sof, ad, ev, es, exp_d);
        end
    endtask

    // Drives one vector; R9 timing: octet k seen k cycles after last accept
    task automatic run_vec(vec_t v, string tag);
        for (int i = 0; i < int'(v.nsmp); i++) begin
            @(negedge clk);
            cfg_res = v.res; cfg_padded = v.pad; cfg_lanes = LW'(v.lanes);
            smp_valid = 1'b1; smp_data = v.smp[i];
            @(posedge clk);
            if (i < int'(v.nsmp) - 1) begin
                @(negedge clk);
                smp_valid = 1'b0;
                @(posedge clk);
            end
        end
        for (int k = 0; k < int'(v.noct); k++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            chk_oct(tag, k, v.oct[k], int'(v.elanes));
            @(posedge clk);
        end
        @(negedge clk);
        chk_idle({tag, " R9 after block"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t tv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after release");

        for (int v = 0; v < NV; v++)
            run_vec(VECS[v], $sformatf("R2 R3 R4 R5 R6 R8 R9 vec %0d", v));

        // R7: mid-block config change applies only to the next block
        @(negedge clk);
        cfg_res = 2'd0; cfg_padded = 1'b0; cfg_lanes = LW'(1);
        smp_valid = 1'b1; smp_data = 16'h0ABC;
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        cfg_res = 2'd2; cfg_padded = 1'b1; cfg_lanes = LW'(2);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 16'h0123;
        @(posedge clk);
        @(negedge clk); smp_valid = 1'b0; chk_oct("R7 old block", 0, 8'hAB, 1);
        @(posedge clk);
        @(negedge clk); chk_oct("R7 old block", 1, 8'hC1, 1);
        @(posedge clk);
        @(negedge clk); chk_oct("R7 old block", 2, 8'h23, 1);
        @(posedge clk);
        @(negedge clk); chk_idle("R7 old block end");
        tv = '{2'd2, 1'b1, 3'd2, 3'd2, 3'd1, {16'h7654, 16'h0, 16'h0, 16'h0}, 4'd2,
               {8'h76, 8'h54, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}};
        run_vec(tv, "R7 new block");

        // R10: 16-bit dense blocks fed every two cycles, no slack
        @(negedge clk);
        cfg_res = 2'd2; cfg_padded = 1'b0; cfg_lanes = LW'(1);
        smp_valid = 1'b1; smp_data = 16'h1111;
        @(posedge clk);
        @(negedge clk); smp_valid = 1'b0; chk_oct("R10 blk A", 0, 8'h11, 1);
        @(posedge clk);
        @(negedge clk); smp_valid = 1'b1; smp_data = 16'h2233; chk_oct("R10 blk A", 1, 8'h11, 1);
        @(posedge clk);
        @(negedge clk); smp_valid = 1'b0; chk_oct("R10 blk B", 0, 8'h22, 1);
        @(posedge clk);
        @(negedge clk); chk_oct("R10 blk B", 1, 8'h33, 1);
        @(posedge clk);
        @(negedge clk); chk_idle("R10 end");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule